// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 63 numbered interrupt request lines, ranks every active, enabled request by a programmable level (1 to 7) and a rank inside that level, and reports the best level to the processor as a 3-bit code. When the processor acknowledges an interrupt at a given level, the block answers with a vector number that identifies the winning source. Software configures it through a flat register interface that holds a pending view, a mask word, a force word, one control register per programmable source, and read-only acknowledge words for each level and for the overall winner.

Sources 1 to 7 are fixed: source n always sits at level n, at the middle of the nine rank positions of that level. Every other source carries a 3-bit level and a 3-bit priority code. Codes 0 to 3 rank below the fixed middle slot and codes 4 to 7 rank above it. If a request is masked after the level code was raised but before the acknowledge arrives, the acknowledge finds nothing and returns a spurious vector.

The acknowledge path is a three-state machine. `ACK_IDLE` waits for `ack_req`, latches `ack_lvl` and moves to `ACK_LOOKUP`. `ACK_LOOKUP` captures the vector of the winner at the latched level and moves to `ACK_REPLY`. `ACK_REPLY` drives `ack_valid` for one cycle and returns to `ACK_IDLE`.

Top module: `irq_rank_ctrl`

## Requirements
- R1: After reset the mask word reads all ones for bits 1..63 (every source disabled), the force word reads 0, every programmable control register reads 0, `ipl` is 0 and `ack_valid` is 0.
- R2: Address 0 reads the pending word: bit n is 1 when `src_req[n]` is high or force bit n is set, 0 otherwise. The mask has no effect on this word, and bit 0 reads 0.
- R3: Address 1 is the mask word. Bit n = 1 removes source n from the level code and from every winner selection, and bit n = 0 enables it. The word reads back as written.
- R4: Address 2 is the force word. Bit n = 1 makes source n pending with `src_req[n]` low, and the source stays pending until software writes the bit back to 0.
- R5: Address 16+n (n = 8..63) is the control register of source n. Bits [5:3] hold the level and bits [2:0] hold the priority code p, and reads return the 6 bits in [5:0]. The rank is p for p < 4 and p+1 for p >= 4. Level 0 means the source is never selected.
- R6: Sources 1..7 are fixed at level n and rank 4. Writes to addresses 17..23 are ignored, and reads return 0x40 | (n << 3).
- R7: `ipl` is registered. One clock after a change it shows the highest level among the pending, unmasked sources whose level is 1..7, or 0 when there are none.
- R8: Within one level the higher rank wins. When ranks are equal, the lower source number wins.
- R9: Address 80+L (L = 1..7) reads the vector 64+n of the winner at level L, or 24 if that level has no candidate. Address 80 reads the vector of the overall winner (highest level first, then R8), or 24.
- R10: `ack_req` is sampled only in `ACK_IDLE`, together with `ack_lvl`. On the next edge the vector of the level winner is captured, using the latched level even if `ack_lvl` has since changed. `ack_valid` is then high for exactly one cycle with `ack_vec`. A requested level of 0 gives 24, and `ack_req` is ignored while the machine is busy.
- R11: If the only request at a level is masked after `ipl` reported that level, an acknowledge at that level returns the spurious vector 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC (63:1) | Request line per source, bit n = source n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational from address) |
| ipl | output | 3 | Encoded highest active level to the processor |
| ack_req | input | 1 | Acknowledge request pulse |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Acknowledge vector valid (one cycle) |
| ack_vec | output | 8 | Acknowledge vector number |

## Verification
The hardest case to reach from the ports is the spurious acknowledge. It needs a request that has already raised `ipl` and is then masked before the acknowledge reaches the lookup state. The bench first lets `ipl` settle on a lone level-4 source. It then writes the mask bit and starts the acknowledge right after the write, so the lookup sees no candidate. A second sequence holds `ack_req` high and changes `ack_lvl` during `ACK_LOOKUP`, which shows that the latched level is used and that requests made while the machine is busy are dropped.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
    localparam int VEC_BASE     = 64;
    localparam int SPURIOUS_VEC = 24;
    localparam int NUM_LVL      = 7;
    localparam int HARDWIRED    = 7;
    localparam int MID_RANK     = 4;

    localparam int A_PEND  = 0;
    localparam int A_MASK  = 1;
    localparam int A_FORCE = 2;
    localparam int A_CTRL  = 16;
    localparam int A_ACK   = 80;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_LOOKUP,
        ACK_REPLY
    } ack_state_e;

    // programmable code 0..3 sits below the fixed middle slot, 4..7 above it
    function automatic logic [3:0] rank_of(input logic [2:0] p);
        return (p < 3'd4) ? {1'b0, p} : ({1'b0, p} + 4'd1);
    endfunction
endpackage

// File: rtl/irq_rank_regs.sv
module irq_rank_regs
    import irq_rank_pkg::*;
#(
    parameter int NSRC   = 63,
    parameter int ADDR_W = 7,
    parameter int DW     = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DW-1:0]          wdata,
    output logic [NSRC:1]          mask_o,
    output logic [NSRC:1]          force_o,
    output logic [NSRC:1][2:0]     lvl_o,
    output logic [NSRC:1][3:0]     rank_o,
    output logic [NSRC:1][6:0]     ctrl_view_o
);
    logic unused_wbit;
    assign unused_wbit = wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o  <= '1;
            force_o <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(A_MASK))  mask_o  <= wdata[NSRC:1];
            if (addr == ADDR_W'(A_FORCE)) force_o <= wdata[NSRC:1];
        end
    end

    for (genvar n = 1; n <= NSRC; n++) begin : g_src
        if (n <= HARDWIRED) begin : g_fixed
            assign lvl_o[n]       = 3'(n);
            assign rank_o[n]      = 4'(MID_RANK);
            assign ctrl_view_o[n] = {1'b1, 3'(n), 3'b000};
        end else begin : g_prog
            logic [5:0] ctrl_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ctrl_q <= '0;
                else if (we && addr == ADDR_W'(A_CTRL + n))
                    ctrl_q <= wdata[5:0];
            end
            assign lvl_o[n]       = ctrl_q[5:3];
            assign rank_o[n]      = rank_of(ctrl_q[2:0]);
            assign ctrl_view_o[n] = {1'b0, ctrl_q};
        end
    end

    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(A_MASK)) |=> (mask_o == $past(wdata[NSRC:1])));

    // R4
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ADDR_W'(A_FORCE)) |=> $stable(force_o));
endmodule

// File: rtl/irq_rank_pick.sv
module irq_rank_pick #(
    parameter int NSRC = 63,
    parameter int LVL  = 1,
    localparam int IW  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]       active,
    input  logic [NSRC:1][2:0]  lvl,
    input  logic [NSRC:1][3:0]  rank,
    output logic                hit,
    output logic [IW-1:0]       idx
);
    logic [3:0] best;

    // ascending scan with strict compare keeps the lower number on a tie
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int n = 1; n <= NSRC; n++) begin
            if (active[n] && lvl[n] == 3'(LVL) && (!hit || rank[n] > best)) begin
                hit  = 1'b1;
                best = rank[n];
                idx  = IW'(n);
            end
        end
    end
endmodule

// File: rtl/irq_rank_ack_fsm.sv
module irq_rank_ack_fsm
    import irq_rank_pkg::*;
#(
    parameter int NSRC = 63,
    localparam int IW  = $clog2(NSRC + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ack_req,
    input  logic [2:0]                  ack_lvl,
    input  logic [NUM_LVL:0]            lvl_hit,
    input  logic [NUM_LVL:0][IW-1:0]    lvl_idx,
    output logic                        ack_valid,
    output logic [7:0]                  ack_vec
);
    ack_state_e st_q, st_d;
    logic [2:0] sel_q;
    logic [7:0] vec_q;

    always_comb begin
        unique case (st_q)
            ACK_IDLE:   st_d = ack_req ? ACK_LOOKUP : ACK_IDLE;
            ACK_LOOKUP: st_d = ACK_REPLY;
            ACK_REPLY:  st_d = ACK_IDLE;
            default:    st_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ACK_IDLE;
            sel_q <= '0;
            vec_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ACK_IDLE && ack_req)
                sel_q <= ack_lvl;
            if (st_q == ACK_LOOKUP)
                vec_q <= lvl_hit[sel_q] ? (8'(VEC_BASE) + 8'(lvl_idx[sel_q]))
                                        : 8'(SPURIOUS_VEC);
        end
    end

    always_comb begin
        ack_valid = (st_q == ACK_REPLY);
        ack_vec   = ack_valid ? vec_q : 8'd0;
    end

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    // R10
    ack_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(st_q == ACK_LOOKUP));

    // R11
    ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_vec == 8'(SPURIOUS_VEC)) ||
                      (ack_vec > 8'(VEC_BASE) && ack_vec <= 8'(VEC_BASE + NSRC)));
endmodule

// File: rtl/irq_rank_ctrl.sv
module irq_rank_ctrl
    import irq_rank_pkg::*;
#(
    parameter int NSRC   = 63,
    parameter int ADDR_W = 7,
    parameter int DW     = 64,
    localparam int IW    = $clog2(NSRC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC:1]       src_req,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic [2:0]          ipl,
    input  logic                ack_req,
    input  logic [2:0]          ack_lvl,
    output logic                ack_valid,
    output logic [7:0]          ack_vec
);
    logic [NSRC:1]          mask_w, force_w, pend_w, active_w;
    logic [NSRC:1][2:0]     lvl_w;
    logic [NSRC:1][3:0]     rank_w;
    logic [NSRC:1][6:0]     view_w;
    logic [NUM_LVL:0]       hit_w;
    logic [NUM_LVL:0][IW-1:0] idx_w;
    logic [2:0]             top_lvl;
    logic [7:0]             lvl_vec [NUM_LVL+1];
    logic [7:0]             top_vec;
    logic [2:0]             ipl_q;

    irq_rank_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .mask_o(mask_w), .force_o(force_w), .lvl_o(lvl_w), .rank_o(rank_w),
        .ctrl_view_o(view_w)
    );

    assign pend_w   = src_req | force_w;
    assign active_w = pend_w & ~mask_w;

    assign hit_w[0] = 1'b0;
    assign idx_w[0] = '0;
    for (genvar L = 1; L <= NUM_LVL; L++) begin : g_lvl
        irq_rank_pick #(.NSRC(NSRC), .LVL(L)) u_pick (
            .active(active_w), .lvl(lvl_w), .rank(rank_w),
            .hit(hit_w[L]), .idx(idx_w[L])
        );
    end

    always_comb begin
        top_lvl = '0;
        for (int L = 1; L <= NUM_LVL; L++)
            if (hit_w[L]) top_lvl = 3'(L);
        for (int L = 0; L <= NUM_LVL; L++)
            lvl_vec[L] = hit_w[L] ? (8'(VEC_BASE) + 8'(idx_w[L])) : 8'(SPURIOUS_VEC);
        top_vec = lvl_vec[top_lvl];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ipl_q <= '0;
        else        ipl_q <= top_lvl;
    end
    assign ipl = ipl_q;

    irq_rank_ack_fsm #(.NSRC(NSRC)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_lvl(ack_lvl),
        .lvl_hit(hit_w), .lvl_idx(idx_w), .ack_valid(ack_valid), .ack_vec(ack_vec)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_PEND))  reg_rdata[NSRC:1] = pend_w;
        if (reg_addr == ADDR_W'(A_MASK))  reg_rdata[NSRC:1] = mask_w;
        if (reg_addr == ADDR_W'(A_FORCE)) reg_rdata[NSRC:1] = force_w;
        for (int n = 1; n <= NSRC; n++)
            if (reg_addr == ADDR_W'(A_CTRL + n)) reg_rdata[6:0] = view_w[n];
        if (reg_addr == ADDR_W'(A_ACK)) reg_rdata[7:0] = top_vec;
        for (int L = 1; L <= NUM_LVL; L++)
            if (reg_addr == ADDR_W'(A_ACK + L)) reg_rdata[7:0] = lvl_vec[L];
    end

    // R7
    ipl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl != 3'd0) |-> $past(|active_w));

    // R7
    ipl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|active_w) |=> (ipl == 3'd0));
endmodule

// File: tb/irq_rank_ctrl_test.sv
`timescale 1ns/1ps
module irq_rank_ctrl_test;
    localparam int NSRC = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC:1] src = '0;
    logic        we = 1'b0;
    logic [6:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [2:0]  ipl;
    logic        ack_req = 1'b0;
    logic [2:0]  ack_lvl = '0;
    logic        ack_valid;
    logic [7:0]  ack_vec;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_rank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_req(src), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .ipl(ipl), .ack_req(ack_req),
        .ack_lvl(ack_lvl), .ack_valid(ack_valid), .ack_vec(ack_vec)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mask[64], m_force[64], m_ctrl[64];
    int ms = 0, m_sel = 0, exp_ipl = 0, exp_vec = 0;

    function automatic int m_level(int n);
        return (n <= 7) ? n : ((m_ctrl[n] >> 3) & 7);
    endfunction
    function automatic int m_rank(int n);
        int p;
        if (n <= 7) return 4;
        p = m_ctrl[n] & 7;
        return (p < 4) ? p : p + 1;
    endfunction
    function automatic int m_win(int L);
        int best = -1;
        int w = 0;
        for (int n = 1; n <= NSRC; n++)
            if ((src[n] || m_force[n] != 0) && m_mask[n] == 0 &&
                m_level(n) == L && m_rank(n) > best) begin
                best = m_rank(n);
                w = n;
            end
        return w;
    endfunction
    function automatic int m_top();
        for (int L = 7; L >= 1; L--)
            if (m_win(L) != 0) return L;
        return 0;
    endfunction
    function automatic int m_vec(int L);
        if (L == 0 || m_win(L) == 0) return 24;
        return 64 + m_win(L);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 64; n++) begin
                m_mask[n] = 1; m_force[n] = 0; m_ctrl[n] = 0;
            end
            ms = 0; exp_ipl = 0;
        end else begin
            exp_ipl = m_top();
            case (ms)
                0: if (ack_req) begin m_sel = ack_lvl; ms = 1; end
                1: begin exp_vec = m_vec(m_sel); ms = 2; end
                default: ms = 0;
            endcase
            if (we) begin
                if (addr == 7'd1) for (int n = 1; n <= NSRC; n++) m_mask[n] = wdata[n];
                if (addr == 7'd2) for (int n = 1; n <= NSRC; n++) m_force[n] = wdata[n];
                for (int n = 8; n <= NSRC; n++)
                    if (addr == 7'(16 + n)) m_ctrl[n] = int'(wdata[5:0]);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(ipl == 3'(exp_ipl), "R7 model ipl", ipl, exp_ipl);
            chk(ack_valid == (ms == 2), "R10 model ack_valid", ack_valid, (ms == 2));
            if (ms == 2) chk(ack_vec == 8'(exp_vec), "R10 model ack_vec", ack_vec, exp_vec);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input logic [63:0] d);
        @(negedge clk); we = 1'b1; addr = 7'(a); wdata = d;
        @(negedge clk); we = 1'b0;
    endtask
    task automatic rd(input int a, input logic [63:0] e, input string tag);
        @(negedge clk); addr = 7'(a); #1;
        chk(rdata == e, tag, rdata, e);
    endtask
    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask
    task automatic do_ack(input int L, input int e, input string tag);
        @(negedge clk); ack_req = 1'b1; ack_lvl = 3'(L);
        @(negedge clk); ack_req = 1'b0;
        @(negedge clk); #1;
        chk(ack_valid && ack_vec == 8'(e), tag, ack_vec, e);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        #1;
        chk(ipl == 0, "R1 ipl", ipl, 0);
        chk(ack_valid == 0, "R1 ack_valid", ack_valid, 0);
        rd(0, 64'h0, "R1 pending");
        rd(1, 64'hFFFF_FFFF_FFFF_FFFE, "R1 mask");
        rd(2, 64'h0, "R1 force");
        rd(16 + 8, 64'h0, "R1 ctrl8");

        // R6 fixed sources
        rd(16 + 3, 64'h58, "R6 ctrl3");
        wr(16 + 3, 64'h0);
        rd(16 + 3, 64'h58, "R6 ctrl3 write ignored");
        rd(16 + 7, 64'h78, "R6 ctrl7");

        // R2 / R7 single source
        wr(1, 64'h0);
        src[2] = 1'b1;
        idle(2);
        chk(ipl == 2, "R7 ipl level2", ipl, 2);
        rd(0, 64'h4, "R2 pending src2");
        do_ack(2, 66, "R10 ack level2");

        // R9 per-level and overall reads
        src[5] = 1'b1;
        idle(2);
        chk(ipl == 5, "R7 ipl level5", ipl, 5);
        rd(80, 64'd69, "R9 overall");
        rd(82, 64'd66, "R9 level2");
        rd(85, 64'd69, "R9 level5");
        rd(81, 64'd24, "R9 empty level");

        // R8 / R5 ranking
        wr(16 + 10, 64'h2F);
        wr(16 + 11, 64'h2F);
        src[10] = 1'b1; src[11] = 1'b1;
        idle(2);
        rd(85, 64'd74, "R8 tie lower number");
        rd(16 + 10, 64'h2F, "R5 ctrl readback");
        wr(16 + 20, 64'h2C);
        wr(16 + 21, 64'h2B);
        src[20] = 1'b1; src[21] = 1'b1;
        wr(1, 64'h0C00);
        idle(2);
        rd(1, 64'h0C00, "R3 mask readback");
        rd(85, 64'd84, "R8 code4 above middle");
        wr(1, 64'h0010_0C00);
        idle(2);
        rd(85, 64'd69, "R8 middle above code3");
        wr(1, 64'h0);

        // R4 force
        wr(16 + 40, 64'h30);
        wr(2, 64'h0000_0100_0000_0000);
        idle(2);
        chk(ipl == 6, "R4 forced ipl", ipl, 6);
        rd(0, 64'h0000_0100_0030_0C24, "R4 pending with force");
        do_ack(6, 104, "R4 ack forced");
        idle(3);
        rd(0, 64'h0000_0100_0030_0C24, "R4 force holds");
        wr(2, 64'h0);
        idle(2);
        chk(ipl == 5, "R4 force cleared", ipl, 5);

        // R5 level 0 never selected
        src[50] = 1'b1;
        idle(2);
        chk(ipl == 5, "R5 level0 ignored", ipl, 5);
        wr(16 + 50, 64'h3F);
        idle(2);
        chk(ipl == 7, "R5 level7 programmed", ipl, 7);
        do_ack(7, 114, "R5 ack level7");
        wr(16 + 50, 64'h0);

        // R11 spurious
        src = '0;
        wr(16 + 30, 64'h21);
        src[30] = 1'b1;
        idle(2);
        chk(ipl == 4, "R11 ipl before mask", ipl, 4);
        wr(1, 64'h4000_0000);
        do_ack(4, 24, "R11 spurious vector");
        chk(ipl == 0, "R11 ipl after mask", ipl, 0);
        do_ack(0, 24, "R10 level0 ack");

        // R10 latched level and busy requests ignored
        wr(1, 64'h0);
        src[3] = 1'b1;
        idle(2);
        @(negedge clk); ack_req = 1'b1; ack_lvl = 3'd4;
        @(negedge clk); ack_lvl = 3'd3;
        @(negedge clk); #1;
        chk(ack_valid && ack_vec == 8'd94, "R10 latched level", ack_vec, 94);
        @(negedge clk); #1;
        chk(ack_valid == 0, "R10 busy request ignored", ack_valid, 0);
        ack_req = 1'b0;
        @(negedge clk); #1;
        chk(ack_valid == 0, "R10 no second reply", ack_valid, 0);
        idle(3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule